// File: doc/BRIEF.md
# Way-Predicted Set-Associative Load Path

This block is the read side of a 4-way, 8 KB data cache that returns load data two cycles after a request is accepted. The request carries the two operands of the address addition, a base and an offset. The block does not wait for their sum before it starts the access. A row decoder tests every cache set for "base + offset equals this set" directly from the operands. A table with one way guess per set is read in the same first cycle. In the second cycle all four ways are read at the decoded row, and the guessed way's 128-bit line is sent out at once as speculative data.

The tag comparison runs on the registered effective address during that second cycle. Its result is reported on a strobe one cycle after the speculative data. A confirm strobe means the guess was right. A mispredict strobe means it was wrong; in that case the line from the way that really hit is sent again, marked as a replay, and the guess table is retrained. A miss strobe means no way matched. The tag and data arrays are synchronous RAMs inside the block. They are written through a simple fill port, and refill policy is left to the surrounding logic.

Top module: `wpc_load_path`

## Requirements
- R1: While reset is held and on the first cycle after it, `ld_valid`, `ld_replay`, `ld_confirm`, `ld_mispredict` and `ld_miss` are 0 and `req_ready` is 1.
- R2: The effective address is base + offset, taken modulo 2^32. Bits [3:0] select the byte, bits [10:4] select the set and bits [31:11] form the tag. The accessed set is the one named by the sum's bits [10:4], including a carry out of the low four bits.
- R3: A request accepted on a clock edge produces, after the second edge that follows, one cycle with `ld_valid`=1, `ld_replay`=0, `ld_way` equal to the predicted way, and `ld_data` equal to that way's line for the set.
- R4: When the predicted way holds the matching tag, `ld_confirm` pulses for one cycle, in the cycle right after the speculative data, and no second delivery follows.
- R5: When a different way holds the matching tag, `ld_mispredict` pulses in the cycle after the speculative data. In that same cycle `ld_valid`=1, `ld_replay`=1, `ld_way` names the matching way and `ld_data` carries its line.
- R6: When no valid way holds the matching tag, `ld_miss` pulses in the cycle after the speculative data, no replay is delivered, and the set's prediction is left unchanged.
- R7: Every load that finds a matching tag writes the matching way into its set's prediction entry, so the next load to that set is predicted to that way.
- R8: In the cycle after a load that will mispredict is accepted, `req_ready` is 0 and no request is taken. A request held through that cycle is accepted on the next edge.
- R9: Loads that do not mispredict may be accepted on consecutive edges; their speculative data and strobes come out in order, one cycle apart.
- R10: A fill (`fill_en`=1) writes a way's tag and line for one set and marks the entry valid. Reset clears every valid flag, so every load misses until the entry is filled again.
- R11: Reset sets every prediction entry to way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_base | input | 32 | Base operand of the address |
| req_offset | input | 32 | Offset operand of the address |
| fill_en | input | 1 | Write one cache entry |
| fill_way | input | 2 | Way to write |
| fill_set | input | 7 | Set to write |
| fill_tag | input | 21 | Tag stored with the entry |
| fill_data | input | 128 | Line stored with the entry |
| ld_valid | output | 1 | Load data is present (speculative or replay) |
| ld_replay | output | 1 | Present data is the corrected replay |
| ld_way | output | 2 | Way the present data was taken from |
| ld_data | output | 128 | Load line data |
| ld_confirm | output | 1 | Prediction verified correct |
| ld_mispredict | output | 1 | Prediction wrong; replay delivered this cycle |
| ld_miss | output | 1 | No way holds the tag |

## Verification
The hardest case to reach is a mispredicting load with a second request already waiting behind it. The stall cycle, the replay and the next load's speculative data then fall on three adjacent cycles that must not collide. The stimulus reaches it directly. It first drives a set whose prediction is known to be wrong, then holds a second request through the stall, and it checks the ready line and each delivery one cycle at a time. Table-driven loads choose base and offset pairs that carry out of the byte field. They cover hits in every way, tag misses and unfilled sets. A reference prediction table in the bench tracks the training and predicts every guess.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

   // outcome of the delayed tag check for one load
   typedef enum logic [1:0] {
      VR_IDLE       = 2'd0,
      VR_CONFIRM    = 2'd1,
      VR_MISPREDICT = 2'd2,
      VR_MISS       = 2'd3
   } wpc_verify_e;

endpackage

// File: rtl/wpc_sum_decoder.sv
// Picks the set named by (base + offset) without forming the sum over the
// index field: each row tests A + B == K with a carry-free identity.
module wpc_sum_decoder #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 4,
   parameter int IDX_W  = 7
) (
   input  logic [ADDR_W-1:0]     base,
   input  logic [ADDR_W-1:0]     offset,
   output logic [(1<<IDX_W)-1:0] row_hit
);
   localparam int ROWS = 1 << IDX_W;

   logic [OFF_W:0]   low_sum;
   logic             cin;
   logic [IDX_W-1:0] fa;
   logic [IDX_W-1:0] fb;

   // only the short byte-field add is done; its carry enters the index field
   assign low_sum = {1'b0, base[OFF_W-1:0]} + {1'b0, offset[OFF_W-1:0]};
   assign cin     = low_sum[OFF_W];
   assign fa      = base[OFF_W +: IDX_W];
   assign fb      = offset[OFF_W +: IDX_W];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      localparam logic [IDX_W-1:0] KROW = IDX_W'(r);
      logic [IDX_W-1:0] carry_out;
      logic [IDX_W-1:0] carry_need;
      // carry each bit must emit if the sum equals KROW
      assign carry_out  = (fa & fb) | ((fa | fb) & ~KROW);
      // carry each bit must receive if the sum equals KROW
      assign carry_need = fa ^ fb ^ KROW;
      assign row_hit[r] = (carry_need == {carry_out[IDX_W-2:0], cin});
   end
endmodule

// File: rtl/wpc_way_predictor.sv
// One way guess per set, read through the decoded row lines.
module wpc_way_predictor #(
   parameter int SETS  = 128,
   parameter int WAY_W = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [SETS-1:0]          row_hit,
   output logic [WAY_W-1:0]         pred_way,
   input  logic                     wr_en,
   input  logic [$clog2(SETS)-1:0]  wr_idx,
   input  logic [WAY_W-1:0]         wr_way
);
   logic [WAY_W-1:0] tbl_q [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SETS; i++) tbl_q[i] <= '0;
      end else if (wr_en) begin
         tbl_q[wr_idx] <= wr_way;
      end
   end

   // AND-OR read selected by the one-hot row lines
   always_comb begin
      pred_way = '0;
      for (int i = 0; i < SETS; i++) begin
         if (row_hit[i]) pred_way = pred_way | tbl_q[i];
      end
   end

   AST_WR_WAY_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !$isunknown(wr_way)); // R7
endmodule

// File: rtl/wpc_sync_ram.sv
// Single-write, single-read synchronous array with registered read data.
module wpc_sync_ram #(
   parameter int DEPTH = 128,
   parameter int WIDTH = 128
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] waddr,
   input  logic [WIDTH-1:0]         wdata,
   input  logic                     re,
   input  logic [$clog2(DEPTH)-1:0] raddr,
   output logic [WIDTH-1:0]         rdata
);
   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/wpc_load_path.sv
module wpc_load_path
   import wpc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int WAYS   = 4,
   parameter int LINE_W = 128,
   parameter int SETS   = 128
) (
   input  logic                                               clk,
   input  logic                                               rst_n,
   input  logic                                               req_valid,
   output logic                                               req_ready,
   input  logic [ADDR_W-1:0]                                  req_base,
   input  logic [ADDR_W-1:0]                                  req_offset,
   input  logic                                               fill_en,
   input  logic [$clog2(WAYS)-1:0]                            fill_way,
   input  logic [$clog2(SETS)-1:0]                            fill_set,
   input  logic [ADDR_W-$clog2(LINE_W/8)-$clog2(SETS)-1:0]    fill_tag,
   input  logic [LINE_W-1:0]                                  fill_data,
   output logic                                               ld_valid,
   output logic                                               ld_replay,
   output logic [$clog2(WAYS)-1:0]                            ld_way,
   output logic [LINE_W-1:0]                                  ld_data,
   output logic                                               ld_confirm,
   output logic                                               ld_mispredict,
   output logic                                               ld_miss
);
   localparam int OFF_W = $clog2(LINE_W/8);
   localparam int IDX_W = $clog2(SETS);
   localparam int WAY_W = $clog2(WAYS);
   localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

   initial begin
      AST_WAYS_POW2:  assert (WAYS >= 2 && WAYS == (1 << WAY_W));
      AST_SETS_POW2:  assert (SETS >= 4 && SETS == (1 << IDX_W));
      AST_LINE_BYTES: assert (LINE_W >= 8 && LINE_W == (8 << OFF_W));
      AST_TAG_ROOM:   assert (TAG_W >= 1);
   end

   // ---------------- cycle 1: decode, predict, launch array reads
   logic [SETS-1:0]   row_hit;
   logic [IDX_W-1:0]  row_idx;
   logic [WAY_W-1:0]  pred_way;
   logic [ADDR_W-1:0] eff_addr;
   logic              accept;

   wpc_sum_decoder #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_dec (
      .base    (req_base),
      .offset  (req_offset),
      .row_hit (row_hit)
   );

   always_comb begin
      row_idx = '0;
      for (int i = 0; i < SETS; i++) begin
         if (row_hit[i]) row_idx = row_idx | IDX_W'(i);
      end
   end

   // full sum, needed only for the later tag check
   assign eff_addr = req_base + req_offset;
   assign accept   = req_valid && req_ready;

   // stage-1 registers
   logic              s1_valid;
   logic [IDX_W-1:0]  s1_row;
   logic [IDX_W-1:0]  s1_sum_idx;
   logic [TAG_W-1:0]  s1_tag;
   logic [WAY_W-1:0]  s1_pred;
   logic [WAYS-1:0]   s1_vld;

   logic [SETS-1:0]   vld_q [WAYS];
   logic [LINE_W-1:0] way_data [WAYS];
   logic [TAG_W-1:0]  way_tag  [WAYS];
   logic [WAYS-1:0]   way_hit;
   logic              hit_any;
   logic [WAY_W-1:0]  hit_way;
   logic              s1_misp;

   logic              pred_wr_en;

   wpc_way_predictor #(.SETS(SETS), .WAY_W(WAY_W)) u_pred (
      .clk      (clk),
      .rst_n    (rst_n),
      .row_hit  (row_hit),
      .pred_way (pred_way),
      .wr_en    (pred_wr_en),
      .wr_idx   (s1_row),
      .wr_way   (hit_way)
   );

   // valid flags live in flops so reset clears them
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WAYS; w++) vld_q[w] <= '0;
      end else if (fill_en) begin
         vld_q[fill_way][fill_set] <= 1'b1;
      end
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic fill_here;
      assign fill_here = fill_en && (fill_way == WAY_W'(w));

      wpc_sync_ram #(.DEPTH(SETS), .WIDTH(LINE_W)) u_data (
         .clk   (clk),
         .we    (fill_here),
         .waddr (fill_set),
         .wdata (fill_data),
         .re    (accept),
         .raddr (row_idx),
         .rdata (way_data[w])
      );

      wpc_sync_ram #(.DEPTH(SETS), .WIDTH(TAG_W)) u_tag (
         .clk   (clk),
         .we    (fill_here),
         .waddr (fill_set),
         .wdata (fill_tag),
         .re    (accept),
         .raddr (row_idx),
         .rdata (way_tag[w])
      );

      assign way_hit[w] = s1_vld[w] && (way_tag[w] == s1_tag);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid   <= 1'b0;
         s1_row     <= '0;
         s1_sum_idx <= '0;
         s1_tag     <= '0;
         s1_pred    <= '0;
         s1_vld     <= '0;
      end else begin
         s1_valid <= accept;
         if (accept) begin
            s1_row     <= row_idx;
            s1_sum_idx <= eff_addr[OFF_W +: IDX_W];
            s1_tag     <= eff_addr[ADDR_W-1 -: TAG_W];
            s1_pred    <= pred_way;
            for (int w = 0; w < WAYS; w++) s1_vld[w] <= vld_q[w][row_idx];
         end
      end
   end

   // ---------------- cycle 2: select predicted way, compare tags
   assign hit_any = |way_hit;

   always_comb begin
      hit_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (way_hit[w]) hit_way = WAY_W'(w);
      end
   end

   assign s1_misp    = s1_valid && hit_any && (hit_way != s1_pred);
   assign req_ready  = !s1_misp;
   assign pred_wr_en = s1_valid && hit_any;

   wpc_verify_e       s2_kind;
   logic [LINE_W-1:0] s2_fix_data;
   logic [WAY_W-1:0]  s2_fix_way;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_kind     <= VR_IDLE;
         s2_fix_data <= '0;
         s2_fix_way  <= '0;
      end else begin
         if (!s1_valid)    s2_kind <= VR_IDLE;
         else if (!hit_any) s2_kind <= VR_MISS;
         else if (s1_misp)  s2_kind <= VR_MISPREDICT;
         else               s2_kind <= VR_CONFIRM;
         s2_fix_data <= way_data[hit_way];
         s2_fix_way  <= hit_way;
      end
   end

   // ---------------- output stage: speculative data, then verdict/replay
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_valid      <= 1'b0;
         ld_replay     <= 1'b0;
         ld_way        <= '0;
         ld_data       <= '0;
         ld_confirm    <= 1'b0;
         ld_mispredict <= 1'b0;
         ld_miss       <= 1'b0;
      end else begin
         ld_valid      <= s1_valid || (s2_kind == VR_MISPREDICT);
         ld_replay     <= (s2_kind == VR_MISPREDICT);
         ld_way        <= s1_valid ? s1_pred : s2_fix_way;
         ld_data       <= s1_valid ? way_data[s1_pred] : s2_fix_data;
         ld_confirm    <= (s2_kind == VR_CONFIRM);
         ld_mispredict <= (s2_kind == VR_MISPREDICT);
         ld_miss       <= (s2_kind == VR_MISS);
      end
   end

   // ---------------- checks
   AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ($countones(row_hit) == 1)); // R2
   AST_ROW_MATCH_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |-> (s1_row == s1_sum_idx)); // R2
   AST_NO_REPLAY_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_kind == VR_MISPREDICT) |-> !s1_valid); // R8
   AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ld_confirm, ld_mispredict, ld_miss})); // R4
   AST_REPLAY_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      ld_replay |-> (ld_mispredict && ld_valid)); // R5
   AST_VERDICT_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_confirm || ld_mispredict || ld_miss) |-> $past(ld_valid && !ld_replay)); // R3
   AST_MISS_NO_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_kind == VR_MISS) |-> $past(!pred_wr_en)); // R6
endmodule

// File: tb/wpc_load_path_tb.sv
module wpc_load_path_tb_top;
   localparam int FILLED = 120;   // sets 120..127 are never filled
   localparam int NV = 10;
   // way (4 = foreign tag), set, byte, offset
   localparam int VEC [NV][4] = '{
      '{0,   5,  3, 'h10},
      '{2,   5,  0, 'h1C},
      '{2,   5,  8, 'h7FC},
      '{1,   9, 15, 'h3},
      '{4,   9,  4, 'h40},
      '{1,   9,  2, 'h0},
      '{3, 125,  1, 'h1F},
      '{3,  64,  2, 'hF},
      '{0,   0,  0, 0},
      '{3, 119, 15, -16}
   };

   logic         clk = 0;
   logic         rst_n = 0;
   logic         req_valid = 0;
   logic         req_ready;
   logic [31:0]  req_base = 0, req_offset = 0;
   logic         fill_en = 0;
   logic [1:0]   fill_way = 0;
   logic [6:0]   fill_set = 0;
   logic [20:0]  fill_tag = 0;
   logic [127:0] fill_data = 0;
   logic         ld_valid, ld_replay, ld_confirm, ld_mispredict, ld_miss;
   logic [1:0]   ld_way;
   logic [127:0] ld_data;

   int checks = 0, failures = 0, mispredicts = 0;
   int ref_pred [128];

   always #4 clk = ~clk;   // 125 MHz

   wpc_load_path dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_base(req_base), .req_offset(req_offset), .fill_en(fill_en),
      .fill_way(fill_way), .fill_set(fill_set), .fill_tag(fill_tag),
      .fill_data(fill_data), .ld_valid(ld_valid), .ld_replay(ld_replay),
      .ld_way(ld_way), .ld_data(ld_data), .ld_confirm(ld_confirm),
      .ld_mispredict(ld_mispredict), .ld_miss(ld_miss)
   );

   function automatic logic [20:0] tagf(int w, int s);
      return 21'(w * 'h1111 + s + 'h100);
   endfunction

   function automatic logic [127:0] linef(int w, int s);
      return {4{8'(w + 'hC0), 8'(s), 16'hBEEF ^ 16'(w * 'h0F0F)}};
   endfunction

   function automatic logic [31:0] addrf(int w, int s, int b);
      logic [20:0] t;
      t = (w < 4) ? tagf(w, s) : 21'h1FFFFF;
      return {t, 7'(s), 4'(b)};
   endfunction

   task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_idle(string req);
      chk(ld_valid == 0, req, ld_valid, 0);
      chk({ld_confirm, ld_mispredict, ld_miss} == 0, req,
          {ld_confirm, ld_mispredict, ld_miss}, 0);
   endtask

   // drives one load at a negedge and checks every later cycle
   task automatic one_load(int w, int s, int b, int off);
      logic [31:0] ea;
      bit miss, misp;
      int pw;
      ea   = addrf(w, s, b);
      miss = (w == 4) || (s >= FILLED);
      pw   = ref_pred[s];
      misp = !miss && (pw != w);
      @(negedge clk);
      req_valid = 1; req_base = ea - 32'(off); req_offset = 32'(off);
      @(negedge clk);
      req_valid = 0;
      chk(req_ready == !misp, "R8 ready after accept", req_ready, !misp);
      @(negedge clk);
      chk(ld_valid && !ld_replay, "R3 speculative valid", {ld_valid, ld_replay}, 2'b10);
      chk(ld_way == 2'(pw), "R3 predicted way", ld_way, pw);
      if (s < FILLED)
         chk(ld_data == linef(pw, s), "R2 row from base+offset", ld_data, linef(pw, s));
      @(negedge clk);
      if (miss) begin
         chk(ld_miss && !ld_confirm && !ld_mispredict, "R6 miss strobe",
             {ld_confirm, ld_mispredict, ld_miss}, 3'b001);
         chk(!ld_valid, "R6 no replay on miss", ld_valid, 0);
      end else if (misp) begin
         mispredicts++;
         chk(ld_mispredict && !ld_confirm && !ld_miss, "R5 mispredict strobe",
             {ld_confirm, ld_mispredict, ld_miss}, 3'b010);
         chk(ld_valid && ld_replay, "R5 replay flagged", {ld_valid, ld_replay}, 2'b11);
         chk(ld_way == 2'(w), "R5 replay way", ld_way, w);
         chk(ld_data == linef(w, s), "R5 replay data", ld_data, linef(w, s));
      end else begin
         chk(ld_confirm && !ld_mispredict && !ld_miss, "R4 confirm strobe",
             {ld_confirm, ld_mispredict, ld_miss}, 3'b100);
         chk(!ld_valid, "R4 no second delivery", ld_valid, 0);
      end
      if (!miss) ref_pred[s] = w;   // R7 training model
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < 128; i++) ref_pred[i] = 0;   // R11
      repeat (3) @(negedge clk);
      chk_idle("R1 during reset");
      chk(req_ready == 1, "R1 ready in reset", req_ready, 1);
      rst_n = 1;
      @(negedge clk);
      chk_idle("R1 after reset");
      chk(req_ready == 1, "R1 ready after reset", req_ready, 1);

      // R10: fill all ways of the filled sets
      for (int s = 0; s < FILLED; s++) begin
         for (int w = 0; w < 4; w++) begin
            fill_en = 1; fill_way = 2'(w); fill_set = 7'(s);
            fill_tag = tagf(w, s); fill_data = linef(w, s);
            @(negedge clk);
         end
      end
      fill_en = 0;

      // table walk: R2..R7, R10 (set 125 unfilled misses)
      for (int v = 0; v < NV; v++) one_load(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);

      // R9: back-to-back confirmed loads (set 5 -> way 2, set 9 -> way 1)
      @(negedge clk);
      req_valid = 1; req_base = addrf(2, 5, 4) - 32'h20; req_offset = 32'h20;
      @(negedge clk);
      chk(req_ready == 1, "R9 ready for second load", req_ready, 1);
      req_base = addrf(1, 9, 6) - 32'h5; req_offset = 32'h5;
      @(negedge clk);
      req_valid = 0;
      chk(ld_valid && ld_data == linef(2, 5), "R9 first data", ld_data, linef(2, 5));
      @(negedge clk);
      chk(ld_confirm, "R9 first confirm", ld_confirm, 1);
      chk(ld_valid && !ld_replay && ld_data == linef(1, 9), "R9 second data",
          ld_data, linef(1, 9));
      @(negedge clk);
      chk(ld_confirm && !ld_valid, "R9 second confirm", {ld_confirm, ld_valid}, 2'b10);

      // R8: mispredicting load (set 20 way 3, predicted 0) with a held request
      @(negedge clk);
      req_valid = 1; req_base = addrf(3, 20, 0) - 32'h9; req_offset = 32'h9;
      @(negedge clk);
      req_base = addrf(2, 5, 1) - 32'h11; req_offset = 32'h11;
      chk(req_ready == 0, "R8 stall after mispredicting accept", req_ready, 0);
      @(negedge clk);
      chk(req_ready == 1, "R8 ready returns", req_ready, 1);
      chk(ld_valid && ld_way == 2'd0 && !ld_replay, "R3 speculative way 0",
          ld_way, 0);
      @(negedge clk);
      req_valid = 0;
      mispredicts++;
      chk(ld_mispredict && ld_replay && ld_way == 2'd3 && ld_data == linef(3, 20),
          "R5 replay of stalled case", ld_data, linef(3, 20));
      @(negedge clk);
      chk(ld_valid && !ld_replay && ld_data == linef(2, 5), "R8 held load delivered",
          ld_data, linef(2, 5));
      @(negedge clk);
      chk(ld_confirm, "R8 held load confirmed", ld_confirm, 1);
      ref_pred[20] = 3;

      // R11, R10: reset clears predictor and valid flags
      @(negedge clk);
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      for (int i = 0; i < 128; i++) ref_pred[i] = 0;
      one_load(4, 9, 0, 'h8);   // set 9 was trained to 1; must predict 0 and miss
      one_load(4, 20, 3, 'h30); // trained to 3 before reset

      $display("mispredictions seen: %0d", mispredicts);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule